// File: doc/BRIEF.md
# Click-Free Gain Code Stepper

This block sequences the gain codes of a two-channel audio path so that a gain change never lands as one large jump at an arbitrary point in the waveform. Each channel receives a requested code, and the block moves the applied code toward it. Codes are signed two's complement in half-dB units. A request outside ±12 dB (±24 codes) is first limited to the nearest end of that range. The block produces only the code sequence; a separate datapath multiplies the samples by the applied code.

A 2-bit mode input, shared by both channels, selects how the applied code moves:
- **Direct load:** the code jumps straight to the target.
- **Ramp:** the code moves one step on each ramp tick.
- **Crossing:** the code moves one step when the channel's own signed sample crosses zero. If no crossing arrives, a sample-count timeout forces the step.
- **Ramp-then-crossing:** a ramp tick arms a step, and the next crossing applies it.

Each channel runs its own three-state machine:
- `ST_IDLE` means the applied code equals the target.
- `ST_WAIT_TICK` waits for a ramp tick.
- `ST_WAIT_ZC` waits for a crossing or the timeout.

The transitions are:
- `ST_IDLE` goes to `ST_WAIT_TICK` when the codes differ in ramp or ramp-then-crossing mode.
- `ST_IDLE` goes to `ST_WAIT_ZC` when the codes differ in crossing mode.
- `ST_WAIT_TICK` goes to `ST_WAIT_ZC` on a tick in ramp-then-crossing mode, or when the mode becomes crossing.
- `ST_WAIT_ZC` goes to `ST_WAIT_TICK` after a step in ramp-then-crossing mode, or when the mode becomes ramp.
- Any state goes to `ST_IDLE` when the codes match, when the final step is taken, or on a direct load.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: After reset both applied codes are 0, and with zero targets `busy` is 0.
- R2: A target code above +24 is treated as +24, and one below -24 is treated as -24. The applied code never leaves [-24, +24].
- R3: With `mode` = 2'b00 (direct load), the applied code equals the limited target on the clock edge after the target is presented.
- R4: With `mode` = 2'b10 (ramp), the applied code moves exactly one code toward the target on the edge that samples `ramp_tick` high. It does not change on edges where `ramp_tick` is low, or when it already equals the target.
- R5: With `mode` = 2'b01 (crossing), a step of one code occurs on the edge that samples a valid sample (`smp_vld` high) that is exactly zero, or whose sign bit differs from that of the previous valid sample. Samples with `smp_vld` low and valid samples that neither cross nor equal zero cause no step. The sign history starts empty at reset.
- R6: In a crossing-timed wait, if TIMEOUT valid samples in a row (default 1024, counted from the cycle after the wait begins or after the last step) bring no crossing, the step is applied on the edge that samples the last of them.
- R7: With `mode` = 2'b11 (ramp-then-crossing), a tick alone causes no step, and a crossing before any tick causes no step. The first crossing after a tick applies one step, and the next step again needs a fresh tick.
- R8: `busy` is high in exactly those cycles where either channel's applied code differs from its limited target. While `busy` is low, the applied codes do not change on the next edge.
- R9: The channels are independent. A channel's samples and target never move the other channel's code.
- R10: Steps go downward as well as upward. A target below the applied code is reached by unit decrements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Transition mode: 00 direct, 01 crossing, 10 ramp, 11 ramp-then-crossing |
| ramp_tick | input | 1 | One-cycle ramp pacing pulse |
| tgt_a | input | GAIN_W | Requested code, channel A (signed half-dB) |
| tgt_b | input | GAIN_W | Requested code, channel B (signed half-dB) |
| smp_vld | input | 1 | Qualifies `smp_a` and `smp_b` |
| smp_a | input | SMP_W | Signed sample, channel A |
| smp_b | input | SMP_W | Signed sample, channel B |
| gain_a | output | GAIN_W | Applied code, channel A |
| gain_b | output | GAIN_W | Applied code, channel B |
| busy | output | 1 | Either channel still moving toward its target |

## Verification
The results arrive at different points relative to their stimulus:
- `busy` is combinational and is valid in the same cycle as a target change.
- A direct load is visible one edge after the target is presented.
- A ramp step is visible on the edge that samples the tick.
- A crossing or timeout step is visible on the edge that samples the qualifying sample.

A changed target must first spend one edge moving the machine out of `ST_IDLE` before any tick or sample can count. The bench therefore drives every input on the falling edge and reads every result on the next falling edge. It keeps `smp_vld` and `ramp_tick` low during that entry edge, so each check lands exactly one register stage after its cause.

// File: rtl/gain_step_pkg.sv
package gain_step_pkg;

    typedef enum logic [1:0] {
        MODE_IMM     = 2'b00,
        MODE_ZC      = 2'b01,
        MODE_RAMP    = 2'b10,
        MODE_RAMP_ZC = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'b00,
        ST_WAIT_TICK = 2'b01,
        ST_WAIT_ZC   = 2'b10
    } step_state_e;

endpackage

// File: rtl/gain_zc_detect.sv
module gain_zc_detect #(
    parameter int SMP_W   = 16,
    parameter int TIMEOUT = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp,
    input  logic             smp_vld,
    input  logic             arm,
    input  logic             step_done,
    output logic             zc_evt,
    output logic             tmo_evt
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    logic             prev_sgn;
    logic             have_prev;
    logic [CNT_W-1:0] wait_cnt;
    logic             hit;

    // a valid sample qualifies if it is zero or its sign flipped
    assign hit     = smp_vld && ((smp == '0) ||
                     (have_prev && (smp[SMP_W-1] != prev_sgn)));
    assign zc_evt  = arm && hit;
    assign tmo_evt = arm && smp_vld && !hit && (wait_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sgn  <= 1'b0;
            have_prev <= 1'b0;
        end else if (smp_vld) begin
            prev_sgn  <= smp[SMP_W-1];
            have_prev <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !arm || step_done) begin
            wait_cnt <= '0;
        end else if (smp_vld && (wait_cnt != CNT_LAST)) begin
            wait_cnt <= wait_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/gain_step_fsm.sv
module gain_step_fsm
    import gain_step_pkg::*;
#(
    parameter int GAIN_W   = 6,
    parameter int MAX_CODE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              ramp_tick,
    input  logic [GAIN_W-1:0] tgt,
    input  logic              zc_evt,
    input  logic              tmo_evt,
    output logic [GAIN_W-1:0] gain,
    output logic              wait_zc,
    output logic              step_done,
    output logic              differ
);
    localparam logic [GAIN_W-1:0] POS_LIM = GAIN_W'(MAX_CODE);
    localparam logic [GAIN_W-1:0] NEG_LIM = GAIN_W'(-MAX_CODE);

    xfer_mode_e        md;
    step_state_e       state, state_n;
    logic [GAIN_W-1:0] tgt_c;
    logic [GAIN_W-1:0] gain_nx;
    logic              load_now;
    logic              step_now;

    assign md = xfer_mode_e'(mode);

    always_comb begin
        if ($signed(tgt) > $signed(POS_LIM)) begin
            tgt_c = POS_LIM;
        end else if ($signed(tgt) < $signed(NEG_LIM)) begin
            tgt_c = NEG_LIM;
        end else begin
            tgt_c = tgt;
        end
    end

    assign differ  = (gain != tgt_c);
    assign gain_nx = ($signed(tgt_c) > $signed(gain)) ? gain + GAIN_W'(1)
                                                      : gain - GAIN_W'(1);

    // next-state and step decision
    always_comb begin
        state_n  = state;
        load_now = 1'b0;
        step_now = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (differ) begin
                    if (md == MODE_IMM) begin
                        load_now = 1'b1;
                    end else if (md == MODE_ZC) begin
                        state_n = ST_WAIT_ZC;
                    end else begin
                        state_n = ST_WAIT_TICK;
                    end
                end
            end
            ST_WAIT_TICK: begin
                if (!differ) begin
                    state_n = ST_IDLE;
                end else if (md == MODE_IMM) begin
                    load_now = 1'b1;
                    state_n  = ST_IDLE;
                end else if (md == MODE_ZC) begin
                    state_n = ST_WAIT_ZC;
                end else if (ramp_tick) begin
                    if (md == MODE_RAMP) begin
                        step_now = 1'b1;
                    end else begin
                        state_n = ST_WAIT_ZC;
                    end
                end
            end
            ST_WAIT_ZC: begin
                if (!differ) begin
                    state_n = ST_IDLE;
                end else if (md == MODE_IMM) begin
                    load_now = 1'b1;
                    state_n  = ST_IDLE;
                end else if (md == MODE_RAMP) begin
                    state_n = ST_WAIT_TICK;
                end else if (zc_evt || tmo_evt) begin
                    step_now = 1'b1;
                    if (md == MODE_RAMP_ZC) begin
                        state_n = ST_WAIT_TICK;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (step_now && (gain_nx == tgt_c)) begin
            state_n = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // output register: the applied code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain <= '0;
        end else if (load_now) begin
            gain <= tgt_c;
        end else if (step_now) begin
            gain <= gain_nx;
        end
    end

    assign wait_zc   = (state == ST_WAIT_ZC);
    assign step_done = step_now;

endmodule

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl #(
    parameter int GAIN_W   = 6,
    parameter int SMP_W    = 16,
    parameter int MAX_CODE = 24,
    parameter int TIMEOUT  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              ramp_tick,
    input  logic [GAIN_W-1:0] tgt_a,
    input  logic [GAIN_W-1:0] tgt_b,
    input  logic              smp_vld,
    input  logic [SMP_W-1:0]  smp_a,
    input  logic [SMP_W-1:0]  smp_b,
    output logic [GAIN_W-1:0] gain_a,
    output logic [GAIN_W-1:0] gain_b,
    output logic              busy
);
    localparam int NUM_CH = 2;

    logic [GAIN_W-1:0] tgt_v  [NUM_CH];
    logic [SMP_W-1:0]  smp_v  [NUM_CH];
    logic [GAIN_W-1:0] gain_v [NUM_CH];
    logic [NUM_CH-1:0] differ_v;

    assign tgt_v[0] = tgt_a;
    assign tgt_v[1] = tgt_b;
    assign smp_v[0] = smp_a;
    assign smp_v[1] = smp_b;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic zc_evt, tmo_evt, wait_zc, step_done;

        gain_zc_detect #(
            .SMP_W   (SMP_W),
            .TIMEOUT (TIMEOUT)
        ) zc_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp       (smp_v[ch]),
            .smp_vld   (smp_vld),
            .arm       (wait_zc),
            .step_done (step_done),
            .zc_evt    (zc_evt),
            .tmo_evt   (tmo_evt)
        );

        gain_step_fsm #(
            .GAIN_W   (GAIN_W),
            .MAX_CODE (MAX_CODE)
        ) fsm_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode),
            .ramp_tick (ramp_tick),
            .tgt       (tgt_v[ch]),
            .zc_evt    (zc_evt),
            .tmo_evt   (tmo_evt),
            .gain      (gain_v[ch]),
            .wait_zc   (wait_zc),
            .step_done (step_done),
            .differ    (differ_v[ch])
        );
    end

    assign gain_a = gain_v[0];
    assign gain_b = gain_v[1];
    assign busy   = |differ_v;

endmodule

// File: rtl/gain_ramp_ctrl_chk.sv
module gain_ramp_ctrl_chk #(
    parameter int GAIN_W   = 6,
    parameter int SMP_W    = 16,
    parameter int MAX_CODE = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              ramp_tick,
    input logic [GAIN_W-1:0] tgt_a,
    input logic [GAIN_W-1:0] tgt_b,
    input logic              smp_vld,
    input logic [SMP_W-1:0]  smp_a,
    input logic [SMP_W-1:0]  smp_b,
    input logic [GAIN_W-1:0] gain_a,
    input logic [GAIN_W-1:0] gain_b,
    input logic              busy
);
    function automatic logic [GAIN_W-1:0] lim(input logic [GAIN_W-1:0] v);
        if ($signed(v) > MAX_CODE)  return GAIN_W'(MAX_CODE);
        if ($signed(v) < -MAX_CODE) return GAIN_W'(-MAX_CODE);
        return v;
    endfunction

    function automatic logic unit_move(input logic [GAIN_W-1:0] now,
                                       input logic [GAIN_W-1:0] was);
        return (now == was) || (now == was + GAIN_W'(1)) ||
               (now == was - GAIN_W'(1));
    endfunction

    assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(gain_a) <= MAX_CODE) && ($signed(gain_a) >= -MAX_CODE) &&
        ($signed(gain_b) <= MAX_CODE) && ($signed(gain_b) >= -MAX_CODE));

    assert_direct_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (gain_a == lim($past(tgt_a))) &&
                            (gain_b == lim($past(tgt_b))));

    assert_ramp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !ramp_tick) |=> $stable(gain_a) && $stable(gain_b));

    assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |=> unit_move(gain_a, $past(gain_a)) &&
                            unit_move(gain_b, $past(gain_b)));

    assert_zc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !smp_vld) |=> $stable(gain_a) && $stable(gain_b));

    assert_combo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !smp_vld) |=> $stable(gain_a) && $stable(gain_b));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(gain_a) && $stable(gain_b));

endmodule

bind gain_ramp_ctrl gain_ramp_ctrl_chk #(
    .GAIN_W   (GAIN_W),
    .SMP_W    (SMP_W),
    .MAX_CODE (MAX_CODE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .ramp_tick (ramp_tick),
    .tgt_a     (tgt_a),
    .tgt_b     (tgt_b),
    .smp_vld   (smp_vld),
    .smp_a     (smp_a),
    .smp_b     (smp_b),
    .gain_a    (gain_a),
    .gain_b    (gain_b),
    .busy      (busy)
);

// File: tb/gain_ramp_ctrl_tb_top.sv
module gain_ramp_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GAIN_W     = 6;
    localparam int SMP_W      = 16;
    localparam int TIMEOUT    = 1024;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        mode;
    logic              ramp_tick;
    logic [GAIN_W-1:0] tgt_a, tgt_b;
    logic              smp_vld;
    logic [SMP_W-1:0]  smp_a, smp_b;
    logic [GAIN_W-1:0] gain_a, gain_b;
    logic              busy;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gain_ramp_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ramp_tick (ramp_tick),
        .tgt_a     (tgt_a),
        .tgt_b     (tgt_b),
        .smp_vld   (smp_vld),
        .smp_a     (smp_a),
        .smp_b     (smp_b),
        .gain_a    (gain_a),
        .gain_b    (gain_b),
        .busy      (busy)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ga();
        return int'($signed(gain_a));
    endfunction

    function automatic int gb();
        return int'($signed(gain_b));
    endfunction

    task automatic send(int sa, int sb);
        smp_a   = SMP_W'(sa);
        smp_b   = SMP_W'(sb);
        smp_vld = 1'b1;
        cyc();
        smp_vld = 1'b0;
    endtask

    task automatic tick();
        ramp_tick = 1'b1;
        cyc();
        ramp_tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "gain_a after reset", ga(), 0);
        chk("R1", "gain_b after reset", gb(), 0);
        chk("R1", "busy after reset", int'(busy), 0);
    endtask

    task automatic t_direct();
        mode  = 2'b00;
        tgt_a = GAIN_W'(10);
        tgt_b = GAIN_W'(-5);
        #1;
        chk("R8", "busy with pending change", int'(busy), 1);
        cyc();
        chk("R3", "gain_a direct load", ga(), 10);
        chk("R3", "gain_b direct load", gb(), -5);
        chk("R8", "busy after load", int'(busy), 0);
        tgt_a = GAIN_W'(30);
        tgt_b = GAIN_W'(-30);
        cyc();
        chk("R2", "gain_a upper limit", ga(), 24);
        chk("R2", "gain_b lower limit", gb(), -24);
        chk("R8", "busy when limited target met", int'(busy), 0);
        tgt_a = '0;
        tgt_b = '0;
        cyc();
        chk("R3", "gain_a back to zero", ga(), 0);
    endtask

    task automatic t_ramp();
        mode  = 2'b10;
        tgt_a = GAIN_W'(3);
        cyc();
        cyc();
        cyc();
        chk("R4", "no step without tick", ga(), 0);
        for (int i = 1; i <= 3; i++) begin
            tick();
            chk("R4", "step per tick", ga(), i);
        end
        chk("R9", "gain_b untouched by ramp of A", gb(), 0);
        chk("R8", "busy after ramp done", int'(busy), 0);
        tick();
        chk("R4", "tick at target holds", ga(), 3);
        tgt_a = GAIN_W'(-2);
        cyc();
        for (int e = 2; e >= -2; e--) begin
            tick();
            chk("R10", "downward step", ga(), e);
        end
    endtask

    task automatic t_zc();
        mode  = 2'b01;
        tgt_a = '0;
        cyc();
        send(100, -100);
        chk("R5", "first sample no history", ga(), -2);
        send(200, 300);
        chk("R5", "same sign no step", ga(), -2);
        smp_a = SMP_W'(-50);
        cyc();
        chk("R5", "invalid crossing ignored", ga(), -2);
        send(-50, 40);
        chk("R5", "sign change step", ga(), -1);
        chk("R9", "gain_b holds on its crossing", gb(), 0);
        send(-60, 0);
        chk("R5", "no crossing no step", ga(), -1);
        send(0, 0);
        chk("R5", "zero sample step", ga(), 0);
        chk("R8", "busy after crossing ramp", int'(busy), 0);
    endtask

    task automatic t_timeout();
        mode  = 2'b01;
        tgt_a = GAIN_W'(1);
        cyc();
        for (int i = 0; i < TIMEOUT - 1; i++) begin
            send(5, 5);
        end
        chk("R6", "no step before timeout", ga(), 0);
        send(5, 5);
        chk("R6", "forced step at timeout", ga(), 1);
    endtask

    task automatic t_combo();
        mode  = 2'b11;
        tgt_a = GAIN_W'(3);
        cyc();
        send(-5, 1);
        chk("R7", "crossing before tick", ga(), 1);
        tick();
        chk("R7", "tick alone", ga(), 1);
        send(5, 1);
        chk("R7", "crossing after tick", ga(), 2);
        send(-5, 1);
        chk("R7", "crossing needs new tick", ga(), 2);
        tick();
        send(0, 1);
        chk("R7", "zero after second tick", ga(), 3);
        chk("R8", "busy after combo", int'(busy), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog R1: actual=hung expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        mode      = 2'b00;
        ramp_tick = 1'b0;
        tgt_a     = '0;
        tgt_b     = '0;
        smp_vld   = 1'b0;
        smp_a     = '0;
        smp_b     = '0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_direct();
        t_ramp();
        t_zc();
        t_timeout();
        t_combo();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule